// File: doc/BRIEF.md
# Delayline Fourfold Event Builder

This block sits behind a four-channel time-to-digital converter that reads out a two-layer delayline anode. Each channel reports the arrival time of one pulse end, measured from a shared start reference. The two ends of the same line form a pair: x1 with x2 on one layer, and y1 with y2 on the orthogonal layer. The block collects one hit per channel. It accepts the event only when all four ends have reported inside a programmable coincidence window. A partial set is thrown away and counted. A set in which one channel fires twice is also thrown away, and counted separately.

For each accepted event the block computes the position on each layer as the signed difference of the two end times. It computes the timing coordinate as the sum of the two end times of each layer, and also as the sum of all four. A configurable constant is subtracted from each sum to remove cable and electronics delays. When folding is enabled, each corrected sum is reduced modulo a programmable period. This lets spectra taken against a divided start reference land on top of each other. The remainder is computed bit-serially, so each accepted event spends a fixed number of cycles in computation before its record is offered on the output stream.

Hits enter through four valid strobes that share one ready. The record leaves through a valid/ready stream. Once a record is offered, it stays on the port with every field unchanged until the consumer takes it. From the moment the fourth hit completes an event until that record is taken, the shared ready stays low. Any hit strobed during that time is ignored. Back-pressure therefore reaches the hit source directly, and no hit is ever half-accepted.

Top module: `dlev_event_builder`

## Requirements
- R1: A record is produced only when channels x1, x2, y1 and y2 have each delivered exactly one hit in the same window. The channels map to hit_valid bits 0, 1, 2 and 3, and the timestamp of channel i is hit_ts[17*i +: 17].
- R2: ev_x equals tx1 minus tx2 and ev_y equals ty1 minus ty2. Both are 18-bit two's complement values.
- R3: With folding off, ev_tsumx is (tx1+tx2−cfg_ofs_pair) mod 2^18, ev_tsumy is (ty1+ty2−cfg_ofs_pair) mod 2^18, and ev_tall is (tx1+tx2+ty1+ty2−cfg_ofs_all) mod 2^19. The sums themselves never overflow.
- R4: With cfg_fold_en high, each offset-corrected sum is further reduced modulo its period: cfg_period_pair for the two pair sums, cfg_period_all for the total. A period of zero leaves that value unfolded.
- R5: Hits are collected in the cycle of the first hit and in the following cfg_window cycles. If the set is still incomplete after the last of those cycles, the held hits are cleared, cnt_incomplete rises by one and no record is produced. An event completed in that last cycle is kept.
- R6: A hit on a channel that already holds a hit drops the whole event, including any hits arriving in that cycle. cnt_multihit rises by one, cnt_incomplete is unchanged, and no record is produced.
- R7: While ev_valid is high and ev_ready low, ev_valid and all record fields stay unchanged. hit_ready is low from the completing hit until the record is taken, and hits strobed meanwhile have no effect.
- R8: After reset, ev_valid is 0, hit_ready is 1 and both counters are 0. The counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_valid | input | 4 | Per-channel hit strobe (bit 0 x1, 1 x2, 2 y1, 3 y2) |
| hit_ts | input | 68 | Four 17-bit timestamps, channel i at bits 17*i upward |
| hit_ready | output | 1 | Shared ready for all hit channels |
| cfg_window | input | 8 | Coincidence window length in cycles after the first hit |
| cfg_ofs_pair | input | 18 | Offset subtracted from each pair sum |
| cfg_ofs_all | input | 19 | Offset subtracted from the four-way sum |
| cfg_fold_en | input | 1 | Enable modulo folding of the time sums |
| cfg_period_pair | input | 18 | Fold period for the pair sums |
| cfg_period_all | input | 19 | Fold period for the four-way sum |
| ev_valid | output | 1 | Result record valid |
| ev_ready | input | 1 | Result record accepted |
| ev_x | output | 18 | Position on the x layer, two's complement |
| ev_y | output | 18 | Position on the y layer, two's complement |
| ev_tsumx | output | 18 | Corrected x pair time sum |
| ev_tsumy | output | 18 | Corrected y pair time sum |
| ev_tall | output | 19 | Corrected four-way time sum |
| cnt_incomplete | output | 16 | Events dropped because the window closed |
| cnt_multihit | output | 16 | Events dropped because a channel fired twice |

## Verification
The hardest cases to reach are the window edges: a set that completes in the very last open cycle, and a set that misses it by one cycle. A late hit must not join the old event. Instead it opens a new partial event, which later times out on its own. The stimulus places hits with single-cycle precision, so both edges are produced deliberately. A stalled output is produced by holding ev_ready low across the whole computation and then strobing hits into the closed input. Dropped or merged events then show up as a scoreboard mismatch or a counter mismatch. Folding is checked with a period larger than the sums, a small period, and a zero period.

// File: rtl/dlev_pkg.sv
package dlev_pkg;
  localparam int unsigned NCH = 4;
  // channel lanes; pairing depends on this order
  localparam int unsigned CH_X1 = 0;
  localparam int unsigned CH_X2 = 1;
  localparam int unsigned CH_Y1 = 2;
  localparam int unsigned CH_Y2 = 3;
  localparam int unsigned NPAIR = NCH / 2;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_LOAD   = 2'd1,
    ST_FOLD   = 2'd2,
    ST_EMIT   = 2'd3
  } dlev_state_e;
endpackage

// File: rtl/dlev_hit_slot.sv
module dlev_hit_slot #(
  parameter int unsigned TS_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            take,
  input  logic [TS_W-1:0] ts_in,
  output logic            held,
  output logic [TS_W-1:0] ts_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      ts_q <= '0;
    end else if (clr) begin
      held <= 1'b0;
    end else if (take) begin
      held <= 1'b1;
      ts_q <= ts_in;
    end
  end

  // R6
  dup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && take |-> clr);

  // R1
  ts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && !clr |=> $stable(ts_q));

endmodule

// File: rtl/dlev_fold.sv
module dlev_fold #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] period,
  output logic         busy,
  output logic [W-1:0] rem
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  d_q;
  logic [W-1:0]  p_q;
  logic [W:0]    r_q;
  logic [W:0]    r_sh;
  logic [W:0]    r_nx;
  logic [CW-1:0] cnt_q;

  // restoring remainder, one dividend bit per cycle; period 0 yields the dividend
  always_comb begin
    r_sh = {r_q[W-1:0], d_q[W-1]};
    r_nx = (r_sh >= {1'b0, p_q}) ? (r_sh - {1'b0, p_q}) : r_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      d_q   <= '0;
      p_q   <= '0;
      r_q   <= '0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      d_q   <= dividend;
      p_q   <= period;
      r_q   <= '0;
      cnt_q <= CW'(W);
    end else if (busy) begin
      d_q   <= {d_q[W-2:0], 1'b0};
      r_q   <= r_nx;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy <= 1'b0;
    end
  end

  assign rem = r_q[W-1:0];

  // R4
  fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && (p_q != '0) |-> rem < p_q);

  // R4
  rem_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> r_q[W] == 1'b0);

endmodule

// File: rtl/dlev_event_builder.sv
module dlev_event_builder
  import dlev_pkg::*;
#(
  parameter int unsigned TS_W  = 17,
  parameter int unsigned WIN_W = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PAIR_W = TS_W + 1,
  localparam int unsigned ALL_W  = TS_W + 2,
  localparam int unsigned DIFF_W = TS_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        hit_valid,
  input  logic [NCH*TS_W-1:0]   hit_ts,
  output logic                  hit_ready,
  input  logic [WIN_W-1:0]      cfg_window,
  input  logic [PAIR_W-1:0]     cfg_ofs_pair,
  input  logic [ALL_W-1:0]      cfg_ofs_all,
  input  logic                  cfg_fold_en,
  input  logic [PAIR_W-1:0]     cfg_period_pair,
  input  logic [ALL_W-1:0]      cfg_period_all,
  output logic                  ev_valid,
  input  logic                  ev_ready,
  output logic [DIFF_W-1:0]     ev_x,
  output logic [DIFF_W-1:0]     ev_y,
  output logic [PAIR_W-1:0]     ev_tsumx,
  output logic [PAIR_W-1:0]     ev_tsumy,
  output logic [ALL_W-1:0]      ev_tall,
  output logic [CNT_W-1:0]      cnt_incomplete,
  output logic [CNT_W-1:0]      cnt_multihit
);

  dlev_state_e      state_q;
  logic [NCH-1:0]   acc;
  logic [NCH-1:0]   held;
  logic [NCH-1:0]   nheld;
  logic [TS_W-1:0]  lane_ts [NCH];
  logic [TS_W-1:0]  slot_ts [NCH];
  logic             dup;
  logic             full;
  logic             expire;
  logic             clr_slots;
  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W-1:0] elapsed;
  logic             fold_start;
  logic [NPAIR-1:0] pair_busy;
  logic [PAIR_W-1:0] pair_sum [NPAIR];
  logic [PAIR_W-1:0] pair_rem [NPAIR];
  logic [ALL_W-1:0]  all_sum;
  logic              all_busy;
  logic [PAIR_W-1:0] per_pair;
  logic [ALL_W-1:0]  per_all;

  assign hit_ready = (state_q == ST_GATHER);
  assign ev_valid  = (state_q == ST_EMIT);
  assign acc       = hit_valid & {NCH{hit_ready}};

  // coincidence bookkeeping for the current cycle
  always_comb begin
    nheld   = held | acc;
    dup     = |(held & acc);
    full    = &nheld;
    elapsed = (held == '0) ? '0 : win_cnt;
    expire  = (|nheld) && (elapsed == cfg_window);
  end

  assign clr_slots = ((state_q == ST_GATHER) && (dup || (!full && expire))) ||
                     ((state_q == ST_EMIT) && ev_ready);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_slot
      assign lane_ts[gi] = hit_ts[gi*TS_W +: TS_W];
      dlev_hit_slot #(.TS_W(TS_W)) slot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_slots),
        .take  (acc[gi]),
        .ts_in (lane_ts[gi]),
        .held  (held[gi]),
        .ts_q  (slot_ts[gi])
      );
    end
  endgenerate

  // window counter: cycles elapsed since the first hit of the open event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (clr_slots || state_q != ST_GATHER || !(|nheld)) begin
      win_cnt <= '0;
    end else begin
      win_cnt <= elapsed + 1'b1;
    end
  end

  // control FSM and drop counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_GATHER;
      cnt_incomplete <= '0;
      cnt_multihit   <= '0;
    end else begin
      unique case (state_q)
        ST_GATHER: begin
          if (dup) begin
            if (cnt_multihit != '1) cnt_multihit <= cnt_multihit + 1'b1;
          end else if (full) begin
            state_q <= ST_LOAD;
          end else if (expire) begin
            if (cnt_incomplete != '1) cnt_incomplete <= cnt_incomplete + 1'b1;
          end
        end
        ST_LOAD: state_q <= ST_FOLD;
        ST_FOLD: if (!(|pair_busy) && !all_busy) state_q <= ST_EMIT;
        ST_EMIT: if (ev_ready) state_q <= ST_GATHER;
        default: state_q <= ST_GATHER;
      endcase
    end
  end

  // positions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_x <= '0;
      ev_y <= '0;
    end else if (state_q == ST_LOAD) begin
      ev_x <= {1'b0, slot_ts[CH_X1]} - {1'b0, slot_ts[CH_X2]};
      ev_y <= {1'b0, slot_ts[CH_Y1]} - {1'b0, slot_ts[CH_Y2]};
    end
  end

  // time sums, offset removal and optional folding
  assign fold_start = (state_q == ST_LOAD);
  assign per_pair   = cfg_fold_en ? cfg_period_pair : '0;
  assign per_all    = cfg_fold_en ? cfg_period_all  : '0;

  generate
    for (gi = 0; gi < NPAIR; gi++) begin : g_pair
      assign pair_sum[gi] = {1'b0, slot_ts[2*gi]} + {1'b0, slot_ts[2*gi+1]} - cfg_ofs_pair;
      dlev_fold #(.W(PAIR_W)) fold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fold_start),
        .dividend (pair_sum[gi]),
        .period   (per_pair),
        .busy     (pair_busy[gi]),
        .rem      (pair_rem[gi])
      );
    end
  endgenerate

  assign all_sum = {2'b0, slot_ts[CH_X1]} + {2'b0, slot_ts[CH_X2]} +
                   {2'b0, slot_ts[CH_Y1]} + {2'b0, slot_ts[CH_Y2]} - cfg_ofs_all;

  dlev_fold #(.W(ALL_W)) fold_all_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fold_start),
    .dividend (all_sum),
    .period   (per_all),
    .busy     (all_busy),
    .rem      (ev_tall)
  );

  assign ev_tsumx = pair_rem[0];
  assign ev_tsumy = pair_rem[1];

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_x) && $stable(ev_y) &&
      $stable(ev_tsumx) && $stable(ev_tsumy) && $stable(ev_tall));

  // R1
  emit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LOAD |-> &held);

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_incomplete - $past(cnt_incomplete)) <= CNT_W'(1));

  // R6
  mh_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_multihit != $past(cnt_multihit) |-> cnt_incomplete == $past(cnt_incomplete));

  // R7
  fold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !(|pair_busy) && !all_busy);

endmodule

// File: tb/dlev_event_builder_tb.sv
module dlev_event_builder_tb_top;
  localparam int TS_W = 17;

  typedef struct {
    logic [17:0] x;
    logic [17:0] y;
    logic [17:0] sx;
    logic [17:0] sy;
    logic [18:0] sa;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hit_valid = '0;
  logic [67:0] hit_ts = '0;
  logic        hit_ready;
  logic [7:0]  cfg_window = 8'd4;
  logic [17:0] cfg_ofs_pair = '0;
  logic [18:0] cfg_ofs_all = '0;
  logic        cfg_fold_en = 1'b0;
  logic [17:0] cfg_period_pair = '0;
  logic [18:0] cfg_period_all = '0;
  logic        ev_valid;
  logic        ev_ready = 1'b1;
  logic [17:0] ev_x, ev_y, ev_tsumx, ev_tsumy;
  logic [18:0] ev_tall;
  logic [15:0] cnt_incomplete, cnt_multihit;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   bp_en = 0;
  bit   hold = 0;
  bit   done = 0;
  int   cyc = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  dlev_event_builder dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ts(hit_ts),
    .hit_ready(hit_ready), .cfg_window(cfg_window), .cfg_ofs_pair(cfg_ofs_pair),
    .cfg_ofs_all(cfg_ofs_all), .cfg_fold_en(cfg_fold_en),
    .cfg_period_pair(cfg_period_pair), .cfg_period_all(cfg_period_all),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_x(ev_x), .ev_y(ev_y),
    .ev_tsumx(ev_tsumx), .ev_tsumy(ev_tsumy), .ev_tall(ev_tall),
    .cnt_incomplete(cnt_incomplete), .cnt_multihit(cnt_multihit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [16:0] a, b, c, d, input string tag);
    exp_t e;
    int unsigned vx, vy, va;
    vx = (32'(a) + 32'(b) - 32'(cfg_ofs_pair)) & 32'h3FFFF;
    vy = (32'(c) + 32'(d) - 32'(cfg_ofs_pair)) & 32'h3FFFF;
    va = (32'(a) + 32'(b) + 32'(c) + 32'(d) - 32'(cfg_ofs_all)) & 32'h7FFFF;
    if (cfg_fold_en && cfg_period_pair != 0) begin
      vx = vx % 32'(cfg_period_pair);
      vy = vy % 32'(cfg_period_pair);
    end
    if (cfg_fold_en && cfg_period_all != 0) va = va % 32'(cfg_period_all);
    e.x  = 18'((32'(a) - 32'(b)) & 32'h3FFFF);
    e.y  = 18'((32'(c) - 32'(d)) & 32'h3FFFF);
    e.sx = 18'(vx);
    e.sy = 18'(vy);
    e.sa = 19'(va);
    e.tag = tag;
    return e;
  endfunction

  // ready generator
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ev_ready <= hold ? 1'b0 : (bp_en ? ((cyc % 3) != 0) : 1'b1);
  end

  // monitor: compares on handshake, checks stability under stall (R7)
  logic        stalled = 0;
  logic [17:0] px, py;
  logic [18:0] pa;
  always @(negedge clk) begin
    #1;
    if (rst_n && ev_valid) begin
      if (stalled) begin
        chk(ev_x == px && ev_y == py && ev_tall == pa, "R7", "stall stability",
            {ev_x, ev_tall}, {px, pa});
      end
      if (ev_ready) begin
        stalled = 0;
        if (q.size() == 0) begin
          chk(0, "R1", "unexpected record", ev_x, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(ev_x == e.x, e.tag, "ev_x R2", ev_x, e.x);
          chk(ev_y == e.y, e.tag, "ev_y R2", ev_y, e.y);
          chk(ev_tsumx == e.sx, e.tag, "ev_tsumx R3", ev_tsumx, e.sx);
          chk(ev_tsumy == e.sy, e.tag, "ev_tsumy R3", ev_tsumy, e.sy);
          chk(ev_tall == e.sa, e.tag, "ev_tall R3", ev_tall, e.sa);
        end
      end else begin
        stalled = 1;
        px = ev_x; py = ev_y; pa = ev_tall;
      end
    end else begin
      stalled = 0;
    end
  end

  task automatic tick(input logic [3:0] m, input logic [16:0] a, b, c, d);
    @(negedge clk);
    hit_valid <= m;
    hit_ts <= {d, c, b, a};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(4'b0, '0, '0, '0, '0);
  endtask

  task automatic drain;
    int g = 0;
    while ((q.size() != 0 || !hit_ready) && g < 3000) begin
      idle(1);
      g++;
    end
    idle(4);
  endtask

  task automatic send4(input logic [16:0] a, b, c, d, input string tag);
    q.push_back(model(a, b, c, d, tag));
    tick(4'b1111, a, b, c, d);
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] inc0, mh0;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    chk(ev_valid == 0, "R8", "ev_valid in reset", ev_valid, 0);
    rst_n = 1'b1;
    idle(2);
    #1;
    chk(ev_valid == 0, "R8", "ev_valid after reset", ev_valid, 0);
    chk(hit_ready == 1, "R8", "hit_ready after reset", hit_ready, 1);
    chk(cnt_incomplete == 0 && cnt_multihit == 0, "R8", "counters after reset",
        {cnt_incomplete, cnt_multihit}, 0);

    // R2 R3 simultaneous hits
    send4(17'd1000, 17'd400, 17'd250, 17'd900, "R2");
    drain();
    // R2 negative diffs, staggered arrival y2, x1, y1, x2
    q.push_back(model(17'd10, 17'd70000, 17'd5, 17'd6, "R2"));
    tick(4'b1000, 0, 0, 0, 17'd6);
    tick(4'b0001, 17'd10, 0, 0, 0);
    tick(4'b0100, 0, 0, 17'd5, 0);
    tick(4'b0010, 0, 17'd70000, 0, 0);
    drain();
    // R3 maximum timestamps, no overflow
    send4(17'h1FFFF, 17'h1FFFF, 17'h1FFFF, 17'h1FFFF, "R3");
    drain();
    // R3 offsets including wrap below zero
    cfg_ofs_pair = 18'd300;
    cfg_ofs_all  = 19'd50000;
    send4(17'd500, 17'd200, 17'd100, 17'd50, "R3");
    drain();
    // R4 fold with small periods
    cfg_ofs_pair = 18'd16;
    cfg_ofs_all  = 19'd40;
    cfg_fold_en = 1'b1;
    cfg_period_pair = 18'd1000;
    cfg_period_all = 19'd777;
    send4(17'd91234, 17'd4321, 17'd60001, 17'd2, "R4");
    drain();
    // R4 period of zero and period above the value
    cfg_period_pair = 18'd0;
    cfg_period_all = 19'd500000;
    send4(17'd3000, 17'd2000, 17'd1500, 17'd700, "R4");
    drain();
    cfg_fold_en = 1'b0;
    cfg_ofs_pair = '0;
    cfg_ofs_all = '0;

    // R5 completion in the last open cycle
    cfg_window = 8'd3;
    inc0 = cnt_incomplete;
    q.push_back(model(17'd77, 17'd66, 17'd55, 17'd44, "R5"));
    tick(4'b0001, 17'd77, 0, 0, 0);
    idle(2);
    tick(4'b1110, 0, 17'd66, 17'd55, 17'd44);
    drain();
    #1;
    chk(cnt_incomplete == inc0, "R5", "last-cycle completion counted", cnt_incomplete, inc0);
    // R5 late hits one cycle after the window: two timeouts, no record
    tick(4'b0001, 17'd1, 0, 0, 0);
    idle(3);
    tick(4'b1110, 0, 17'd2, 17'd3, 17'd4);
    idle(8);
    drain();
    #1;
    chk(cnt_incomplete == inc0 + 2, "R5", "timeouts after late hit", cnt_incomplete, inc0 + 2);
    chk(q.size() == 0, "R1", "no record from partial sets", q.size(), 0);
    // R5 window of zero: only simultaneous sets survive
    cfg_window = 8'd0;
    send4(17'd9, 17'd8, 17'd7, 17'd6, "R5");
    drain();
    tick(4'b0011, 17'd9, 17'd8, 0, 0);
    tick(4'b1100, 0, 0, 17'd7, 17'd6);
    idle(3);
    drain();
    #1;
    chk(cnt_incomplete == inc0 + 4, "R5", "zero window partials", cnt_incomplete, inc0 + 4);

    // R6 multi-hit
    cfg_window = 8'd8;
    inc0 = cnt_incomplete;
    mh0 = cnt_multihit;
    tick(4'b0001, 17'd5, 0, 0, 0);
    tick(4'b0001, 17'd6, 0, 0, 0);
    idle(12);
    tick(4'b0100, 0, 0, 17'd5, 0);
    tick(4'b1111, 17'd1, 17'd2, 17'd3, 17'd4);
    idle(12);
    drain();
    #1;
    chk(cnt_multihit == mh0 + 2, "R6", "multi-hit count", cnt_multihit, mh0 + 2);
    chk(cnt_incomplete == inc0, "R6", "incomplete untouched", cnt_incomplete, inc0);
    chk(q.size() == 0, "R6", "no record from multi-hit", q.size(), 0);

    // R7 back-pressure pattern
    bp_en = 1;
    for (int k = 0; k < 6; k++) begin
      send4(17'(100 * k + 3), 17'(7 * k), 17'(50000 - k), 17'(k * k), "R7");
      drain();
    end
    bp_en = 0;

    // R7 hits during a stall are ignored
    hold = 1;
    mh0 = cnt_multihit;
    send4(17'd11, 17'd22, 17'd33, 17'd44, "R7");
    idle(30);
    #1;
    chk(ev_valid == 1 && hit_ready == 0, "R7", "stalled output holds", {ev_valid, hit_ready}, 2'b10);
    tick(4'b0001, 17'd99, 0, 0, 0);
    tick(4'b1111, 17'd98, 17'd97, 17'd96, 17'd95);
    idle(3);
    hold = 0;
    drain();
    send4(17'd1, 17'd2, 17'd3, 17'd4, "R7");
    drain();
    #1;
    chk(cnt_multihit == mh0, "R7", "stalled hits left no trace", cnt_multihit, mh0);
    chk(q.size() == 0, "R7", "scoreboard empty", q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule